// File: doc/BRIEF.md
# Critical-Word Residency Monitor

This block sits beside a small set-associative data cache and measures how long cached words spend in a state where a single upset would escape the cache. A word is exposed between its fill and the CPU's last read of it. It is also exposed between the CPU's last write to it and the write-back of its line. Time outside those windows is not charged. The monitor receives one cache event per cycle: line fill, CPU word read, CPU word write, line eviction (with a flag saying whether the line is written back), and line invalidate.

For every word of every line, the monitor keeps a state and a start timestamp. It adds each closed exposure interval into a saturating critical-time total. Next to that total, it keeps a saturating count of elapsed cycles. A host divides the first by the second and by the word count to get the fraction of word-cycles at risk. A synchronous clear restarts both counts and forgets every open interval.

Top module: `crit_residency_mon`

## Requirements
- R1: After reset, or in the cycle after `clr_i` is high, `crit_total_o` and `elapsed_o` are zero and every word is non-critical. A read that follows without a new fill adds nothing.
- R2: `elapsed_o` increases by one every cycle, starting from zero. An event presented while `elapsed_o` equals N is timestamped N, and its effect shows in `crit_total_o` one cycle later.
- R3: A CPU read of a word whose line was filled, and which has not been written since, adds (read cycle − fill cycle). Other words are not charged.
- R4: Repeated reads of one word charge, in total, exactly (last read cycle − fill cycle).
- R5: A dirty eviction charges a written word (eviction cycle − cycle of its last write). Time before the last write is not charged.
- R6: A clean eviction (`ev_dirty_i` low) or an invalidate charges nothing and closes every open interval of the line. A later read of such a word, without a new fill, adds nothing.
- R7: A read of a word that has been written since its fill adds nothing, because its dirty interval already covers those cycles.
- R8: A dirty eviction charges every written word of the line in the same cycle. Words of that line that were only filled or read are not charged.
- R9: `crit_total_o` and `elapsed_o` saturate at all ones and hold there until cleared.
- R10: Event codes on `ev_op_i` are: 0 none, 1 fill, 2 read, 3 write, 4 evict, 5 invalidate. Codes 6 and 7 act as none. The line is (`ev_set_i`, `ev_way_i`), and `ev_word_i` selects the word for a read or a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of counts and word states |
| ev_op_i | input | 3 | Event code (R10) |
| ev_set_i | input | SET_W | Set of the event's line |
| ev_way_i | input | WAY_W | Way of the event's line |
| ev_word_i | input | WORD_W | Word within the line for read or write |
| ev_dirty_i | input | 1 | Eviction writes the line back |
| crit_total_o | output | ACC_W | Saturating sum of critical time |
| elapsed_o | output | CNT_W | Saturating elapsed-cycle count |

## Verification
The bench builds the monitor with four sets, two ways and four words per line, and with 12-bit counters. The narrow counters put saturation of both the elapsed count and the critical total within a few thousand cycles, so the clamp and hold behaviour is exercised directly. With two ways and four words per line, a single dirty eviction can mix written, read-pending and idle words. Events can also land on distinct lines in adjacent sets, which shows that charges stay local to their line.

// File: rtl/cwm_pkg.sv
package cwm_pkg;
    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_FILL  = 3'd1,
        EV_READ  = 3'd2,
        EV_WRITE = 3'd3,
        EV_EVICT = 3'd4,
        EV_INVAL = 3'd5
    } cwm_op_e;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_RDPND = 2'd1,
        WS_DIRTY = 2'd2
    } cwm_wstate_e;
endpackage

// File: rtl/cwm_cycle_counter.sv
module cwm_cycle_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [CNT_W-1:0] now_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i)
            s_d.cnt = '0;
        else if (s_q.cnt != CNT_MAX)
            s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign now_o = s_q.cnt;

    // R2
    cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && now_o != CNT_MAX) |=> now_o == $past(now_o) + 1'b1);
    // R9
    cycle_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && now_o == CNT_MAX) |=> now_o == CNT_MAX);
    // R1
    cycle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> now_o == '0);
endmodule

// File: rtl/cwm_word_table.sv
module cwm_word_table
    import cwm_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int WPL   = 4,
    parameter int CNT_W = 48,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int WORD_W = (WPL > 1) ? $clog2(WPL) : 1,
    localparam int CR_W   = CNT_W + $clog2(WPL) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  cwm_op_e           op_i,
    input  logic [SET_W-1:0]  set_i,
    input  logic [WAY_W-1:0]  way_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              dirty_i,
    input  logic [CNT_W-1:0]  now_i,
    output logic [CR_W-1:0]   credit_o
);
    localparam int NW    = SETS * WAYS * WPL;
    localparam int IDX_W = $clog2(NW);

    typedef struct packed {
        cwm_wstate_e [NW-1:0]            st;
        logic [NW-1:0][CNT_W-1:0]        ts;
    } tbl_st_t;

    tbl_st_t t_d, t_q;
    logic [IDX_W-1:0] base_idx;
    logic [IDX_W-1:0] word_idx;
    logic [CNT_W-1:0] span;
    logic [CR_W-1:0]  credit;

    always_comb begin
        base_idx = IDX_W'((int'(set_i) * WAYS + int'(way_i)) * WPL);
        word_idx = base_idx + IDX_W'(word_i);
    end

    always_comb begin
        t_d    = t_q;
        credit = '0;
        span   = '0;
        if (clr_i) begin
            for (int i = 0; i < NW; i++) t_d.st[i] = WS_IDLE;
        end else begin
            case (op_i)
                EV_FILL: begin
                    for (int w = 0; w < WPL; w++) begin
                        t_d.st[int'(base_idx) + w] = WS_RDPND;
                        t_d.ts[int'(base_idx) + w] = now_i;
                    end
                end
                EV_READ: begin
                    if (t_q.st[word_idx] == WS_RDPND) begin
                        span             = now_i - t_q.ts[word_idx];
                        credit           = CR_W'(span);
                        t_d.ts[word_idx] = now_i;
                    end
                end
                EV_WRITE: begin
                    t_d.st[word_idx] = WS_DIRTY;
                    t_d.ts[word_idx] = now_i;
                end
                EV_EVICT: begin
                    for (int w = 0; w < WPL; w++) begin
                        if (dirty_i && t_q.st[int'(base_idx) + w] == WS_DIRTY) begin
                            span   = now_i - t_q.ts[int'(base_idx) + w];
                            credit = credit + CR_W'(span);
                        end
                        t_d.st[int'(base_idx) + w] = WS_IDLE;
                    end
                end
                EV_INVAL: begin
                    for (int w = 0; w < WPL; w++) t_d.st[int'(base_idx) + w] = WS_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign credit_o = credit;

    // R3
    read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == EV_READ) |-> credit_o <= CR_W'(now_i));
    // R6
    clean_evict_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == EV_EVICT && !dirty_i) || op_i == EV_INVAL || op_i == EV_FILL) |-> credit_o == '0);
    // R7
    dirty_read_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == EV_READ && t_q.st[word_idx] == WS_DIRTY) |-> credit_o == '0);
    // R1
    clear_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> credit_o == '0);
endmodule

// File: rtl/cwm_sat_accum.sv
module cwm_sat_accum #(
    parameter int ACC_W = 48,
    parameter int CR_W  = 51
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [CR_W-1:0]  credit_i,
    output logic [ACC_W-1:0] total_o
);
    localparam int SUM_W = ((ACC_W > CR_W) ? ACC_W : CR_W) + 1;
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_st_t;

    acc_st_t a_d, a_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        a_d = a_q;
        sum = SUM_W'(a_q.acc) + SUM_W'(credit_i);
        if (clr_i)
            a_d.acc = '0;
        else if (sum > SUM_W'(ACC_MAX))
            a_d.acc = ACC_MAX;
        else
            a_d.acc = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign total_o = a_q.acc;

    // R9
    total_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> total_o >= $past(total_o));
    // R9
    total_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && total_o == ACC_MAX) |=> total_o == ACC_MAX);
    // R1
    total_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> total_o == '0);
endmodule

// File: rtl/crit_residency_mon.sv
module crit_residency_mon
    import cwm_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int WPL   = 4,
    parameter int CNT_W = 48,
    parameter int ACC_W = 48,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int WORD_W = (WPL > 1) ? $clog2(WPL) : 1,
    localparam int CR_W   = CNT_W + $clog2(WPL) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [2:0]        ev_op_i,
    input  logic [SET_W-1:0]  ev_set_i,
    input  logic [WAY_W-1:0]  ev_way_i,
    input  logic [WORD_W-1:0] ev_word_i,
    input  logic              ev_dirty_i,
    output logic [ACC_W-1:0]  crit_total_o,
    output logic [CNT_W-1:0]  elapsed_o
);
    cwm_op_e          op;
    logic [CNT_W-1:0] now;
    logic [CR_W-1:0]  credit;

    assign op = cwm_op_e'(ev_op_i);

    cwm_cycle_counter #(.CNT_W(CNT_W)) u_clock (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .now_o (now)
    );

    cwm_word_table #(
        .SETS(SETS), .WAYS(WAYS), .WPL(WPL), .CNT_W(CNT_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_i),
        .op_i     (op),
        .set_i    (ev_set_i),
        .way_i    (ev_way_i),
        .word_i   (ev_word_i),
        .dirty_i  (ev_dirty_i),
        .now_i    (now),
        .credit_o (credit)
    );

    cwm_sat_accum #(.ACC_W(ACC_W), .CR_W(CR_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_i),
        .credit_i (credit),
        .total_o  (crit_total_o)
    );

    assign elapsed_o = now;

    // R10
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && ev_op_i > 3'd5) |=> crit_total_o == $past(crit_total_o));
endmodule

// File: tb/crit_residency_mon_test.sv
module crit_residency_mon_test;
    localparam int CW = 12;
    localparam logic [CW-1:0] TOP = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic [2:0] op = 3'd0;
    logic [1:0] set = 2'd0;
    logic way = 1'b0;
    logic [1:0] word = 2'd0;
    logic dirty = 1'b0;
    logic [CW-1:0] total;
    logic [CW-1:0] elapsed;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    crit_residency_mon #(.SETS(4), .WAYS(2), .WPL(4), .CNT_W(CW), .ACC_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .ev_op_i(op), .ev_set_i(set),
        .ev_way_i(way), .ev_word_i(word), .ev_dirty_i(dirty),
        .crit_total_o(total), .elapsed_o(elapsed)
    );

    typedef struct packed {
        logic [23:0]   req;
        logic [CW-1:0] cyc;
        logic [2:0]    op;
        logic [1:0]    set;
        logic          way;
        logic [1:0]    word;
        logic          dirty;
        logic [CW-1:0] exp;
    } vec_t;

    // codes: 1 fill, 2 read, 3 write, 4 evict, 5 invalidate, 7 none (R10)
    localparam vec_t VECS [24] = '{
        '{"R3 ", 12'd10,  3'd1, 2'd0, 1'b0, 2'd0, 1'b0, 12'd0},
        '{"R3 ", 12'd20,  3'd1, 2'd1, 1'b1, 2'd0, 1'b0, 12'd0},
        '{"R3 ", 12'd40,  3'd2, 2'd0, 1'b0, 2'd0, 1'b0, 12'd30},
        '{"R4 ", 12'd45,  3'd2, 2'd0, 1'b0, 2'd0, 1'b0, 12'd35},
        '{"R5 ", 12'd50,  3'd3, 2'd1, 1'b1, 2'd2, 1'b0, 12'd35},
        '{"R7 ", 12'd60,  3'd2, 2'd1, 1'b1, 2'd2, 1'b0, 12'd35},
        '{"R5 ", 12'd70,  3'd3, 2'd1, 1'b1, 2'd3, 1'b0, 12'd35},
        '{"R3 ", 12'd80,  3'd2, 2'd0, 1'b0, 2'd1, 1'b0, 12'd105},
        '{"R5 ", 12'd90,  3'd3, 2'd0, 1'b0, 2'd1, 1'b0, 12'd105},
        '{"R8 ", 12'd100, 3'd4, 2'd1, 1'b1, 2'd0, 1'b1, 12'd185},
        '{"R6 ", 12'd110, 3'd2, 2'd1, 1'b1, 2'd2, 1'b0, 12'd185},
        '{"R6 ", 12'd120, 3'd4, 2'd0, 1'b0, 2'd0, 1'b0, 12'd185},
        '{"R5 ", 12'd130, 3'd1, 2'd2, 1'b0, 2'd0, 1'b0, 12'd185},
        '{"R5 ", 12'd140, 3'd3, 2'd2, 1'b0, 2'd0, 1'b0, 12'd185},
        '{"R5 ", 12'd150, 3'd3, 2'd2, 1'b0, 2'd0, 1'b0, 12'd185},
        '{"R5 ", 12'd170, 3'd4, 2'd2, 1'b0, 2'd0, 1'b1, 12'd205},
        '{"R6 ", 12'd180, 3'd1, 2'd3, 1'b1, 2'd0, 1'b0, 12'd205},
        '{"R6 ", 12'd190, 3'd5, 2'd3, 1'b1, 2'd0, 1'b0, 12'd205},
        '{"R6 ", 12'd200, 3'd2, 2'd3, 1'b1, 2'd0, 1'b0, 12'd205},
        '{"R3 ", 12'd210, 3'd1, 2'd3, 1'b1, 2'd0, 1'b0, 12'd205},
        '{"R8 ", 12'd230, 3'd3, 2'd3, 1'b1, 2'd1, 1'b0, 12'd205},
        '{"R3 ", 12'd250, 3'd2, 2'd3, 1'b1, 2'd0, 1'b0, 12'd245},
        '{"R8 ", 12'd260, 3'd4, 2'd3, 1'b1, 2'd0, 1'b1, 12'd275},
        '{"R10", 12'd280, 3'd7, 2'd0, 1'b0, 2'd0, 1'b1, 12'd275}
    };

    task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic at_cycle(input logic [CW-1:0] n);
        while (elapsed != n) @(negedge clk);
    endtask

    task automatic apply(input logic [2:0] o, input logic [1:0] s, input logic w,
                         input logic [1:0] wd, input logic d);
        op = o; set = s; way = w; word = wd; dirty = d;
        @(negedge clk);
        op = 3'd0; dirty = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset total", total, '0);
        check("R1 reset elapsed", elapsed, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 first count", elapsed, 12'd1);
        @(negedge clk);
        check("R2 second count", elapsed, 12'd2);

        foreach (VECS[i]) begin
            at_cycle(VECS[i].cyc);
            apply(VECS[i].op, VECS[i].set, VECS[i].way, VECS[i].word, VECS[i].dirty);
            check(string'(VECS[i].req), total, VECS[i].exp);
            check("R2 timestamp", elapsed, VECS[i].cyc + 1'b1);
        end

        // R1: clear restarts counts and forgets open intervals
        at_cycle(12'd300);
        apply(3'd1, 2'd0, 1'b0, 2'd0, 1'b0);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R1 clear total", total, '0);
        check("R1 clear elapsed", elapsed, '0);
        at_cycle(12'd5);
        apply(3'd2, 2'd0, 1'b0, 2'd0, 1'b0);
        check("R1 read after clear", total, '0);

        // R9: accumulator saturation
        at_cycle(12'd10);
        apply(3'd1, 2'd0, 1'b0, 2'd0, 1'b0);
        at_cycle(12'd12);
        apply(3'd1, 2'd1, 1'b0, 2'd0, 1'b0);
        at_cycle(12'd3000);
        apply(3'd2, 2'd0, 1'b0, 2'd0, 1'b0);
        check("R3 long read", total, 12'd2990);
        at_cycle(12'd3002);
        apply(3'd2, 2'd1, 1'b0, 2'd0, 1'b0);
        check("R9 total clamp", total, TOP);

        // R9: elapsed count saturation
        at_cycle(TOP);
        repeat (3) @(negedge clk);
        check("R9 elapsed hold", elapsed, TOP);
        apply(3'd2, 2'd0, 1'b0, 2'd0, 1'b0);
        check("R9 total hold", total, TOP);

        report();
    end
endmodule